// File: doc/BRIEF.md
# Programmable Interrupt Level Controller

This block gathers interrupt requests from a parameterised set of on-chip peripheral sources and from two external pins. It folds them onto eight interrupt levels with fixed relative priority. Each source has its own routing register: a three-bit level number and an enable bit. Any source can therefore be steered to any level, and several sources can share one level, where their requests are ORed together. Each level also has an enable bit.

The block shows the processor two things: a single request line and the number of the highest eligible level. The processor answers with an acknowledge that names the level it is about to service. An acknowledged level is marked in service and is left out of the request. The mark clears by itself once every source on that level has dropped. Pending state is never cleared by software. It follows the source lines, which are level-sensitive and active-high. The external pins pass through a two-flop synchroniser. Internal sources are assumed to be synchronous to the block clock.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous reset, irq_req is 0, irq_level is 0, lvl_pend is 0, every source register reads 0 (disabled, level 0) and the level-enable register reads 0.
- R2: Register map, with cfg_addr 0 to N_INT-1 for the internal sources and N_INT, N_INT+1 for the external pins 0 and 1. Each source register holds the level in bits [2:0] and the source enable in bit 3. Bits [7:4] are not stored and read as 0. Address N_INT+2 holds the level-enable mask, with bit n enabling level n. Other addresses read 0, and writes to them change nothing.
- R3: An enabled internal source that is high sets the lvl_pend bit of its assigned level one clock edge later.
- R4: Sources assigned to the same level are ORed together. The level stays pending while any of them is high.
- R5: irq_level reports the highest-numbered eligible level (7 highest, 0 lowest), and irq_req is 1 whenever one exists. With no eligible level, irq_req and irq_level are 0.
- R6: A level whose enable bit is 0 never asserts irq_req, and its lvl_pend bit reads 0.
- R7: A source whose enable bit is 0 has no effect on any level.
- R8: An external pin change reaches lvl_pend and irq_level three clock edges after it is applied, and not after two.
- R9: Raising ack_valid with ack_level = n removes level n from the request from the second edge on. The level becomes eligible again once all its sources have dropped and one of them rises again.
- R10: An acknowledge does not clear pending status: lvl_pend keeps the acknowledged level's bit while its sources stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| int_irq | input | N_INT | Internal source requests, active high, synchronous |
| ext_irq | input | 2 | External pin requests, active high, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(N_INT+3) | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational from cfg_addr |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| irq_req | output | 1 | Request to the processor |
| irq_level | output | 3 | Highest eligible level |
| lvl_pend | output | 8 | Per-level pending status, enabled levels only |

## Verification
The hardest state to reach is a level that is acknowledged but whose sources are still high. Here pending must stay visible while the request moves to a lower level, and the in-service mark must clear only when the level's sources drop. The bench routes two internal sources to two levels and acknowledges the higher one. It then checks that the request falls to the lower level while the pending bit holds. Next it drops the high source and re-raises it, and confirms the high level returns. A second sequence exercises the synchroniser. It samples one edge before and at the edge on which an external pin may first appear.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int IRQ_LVLS  = 8;
   localparam int IRQ_LVL_W = $clog2(IRQ_LVLS);

   typedef logic [IRQ_LVL_W-1:0] lvl_t;
   typedef logic [IRQ_LVLS-1:0]  lvl_vec_t;

   typedef struct packed {
      logic en;
      lvl_t lvl;
   } src_cfg_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int NSRC = 8,
   parameter int AW   = 4
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      we,
   input  logic [AW-1:0]             addr,
   input  logic [IRQ_LVLS-1:0]       wdata,
   output logic [IRQ_LVLS-1:0]       rdata,
   output src_cfg_t [NSRC-1:0]       src_cfg,
   output lvl_vec_t                  lvl_en
);
   localparam int SW     = $clog2(NSRC);
   localparam int EN_ADR = NSRC;

   src_cfg_t [NSRC-1:0] cfg_q;
   lvl_vec_t            en_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '0;
         en_q  <= '0;
      end else if (we) begin
         if (int'(addr) < NSRC)
            cfg_q[addr[SW-1:0]] <= wdata[IRQ_LVL_W:0];
         else if (int'(addr) == EN_ADR)
            en_q <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (int'(addr) < NSRC)
         rdata[IRQ_LVL_W:0] = cfg_q[addr[SW-1:0]];
      else if (int'(addr) == EN_ADR)
         rdata = en_q;
   end

   assign src_cfg = cfg_q;
   assign lvl_en  = en_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import irq_pkg::*;
(
   input  lvl_vec_t req,
   output logic     any,
   output lvl_t     idx
);
   always_comb begin
      idx = '0;
      for (int l = 0; l < IRQ_LVLS; l++)
         if (req[l]) idx = IRQ_LVL_W'(l);
   end
   assign any = |req;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
   import irq_pkg::*;
#(
   parameter int N_INT       = 6,
   parameter int N_EXT       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [N_INT-1:0]                int_irq,
   input  logic [N_EXT-1:0]                ext_irq,
   input  logic                            cfg_we,
   input  logic [$clog2(N_INT+N_EXT+1)-1:0] cfg_addr,
   input  logic [IRQ_LVLS-1:0]             cfg_wdata,
   output logic [IRQ_LVLS-1:0]             cfg_rdata,
   input  logic                            ack_valid,
   input  logic [IRQ_LVL_W-1:0]            ack_level,
   output logic                            irq_req,
   output logic [IRQ_LVL_W-1:0]            irq_level,
   output logic [IRQ_LVLS-1:0]             lvl_pend
);
   localparam int NSRC = N_INT + N_EXT;
   localparam int AW   = $clog2(NSRC + 1);

   if (N_INT < 1)            begin : g_bad_int  $error("N_INT must be at least 1"); end
   if (N_EXT != 2)           begin : g_bad_ext  $error("N_EXT must be 2"); end
   if (SYNC_STAGES < 2)      begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
   if (IRQ_LVL_W + 1 > IRQ_LVLS) begin : g_bad_w $error("config field wider than data bus"); end

   logic [N_EXT-1:0]    ext_s;
   logic [NSRC-1:0]     src;
   src_cfg_t [NSRC-1:0] src_cfg;
   lvl_vec_t            lvl_en;
   lvl_vec_t            lvl_raw, lvl_act, eligible, isr_q;
   logic                enc_any;
   lvl_t                enc_idx;

   irq_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(ext_irq), .q(ext_s)
   );

   irq_cfg_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
      .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .src_cfg(src_cfg), .lvl_en(lvl_en)
   );

   assign src = {ext_s, int_irq};

   always_comb begin
      lvl_raw = '0;
      for (int s = 0; s < NSRC; s++)
         if (src_cfg[s].en && src[s]) lvl_raw[src_cfg[s].lvl] = 1'b1;
   end

   assign lvl_act  = lvl_raw & lvl_en;
   assign eligible = lvl_act & ~isr_q;

   irq_prio_enc u_enc (.req(eligible), .any(enc_any), .idx(enc_idx));

   always_ff @(posedge clk) begin
      if (rst) begin
         isr_q <= '0;
      end else begin
         for (int l = 0; l < IRQ_LVLS; l++) begin
            if (ack_valid && ack_level == IRQ_LVL_W'(l)) isr_q[l] <= 1'b1;
            else if (!lvl_act[l])                        isr_q[l] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_req   <= 1'b0;
         irq_level <= '0;
         lvl_pend  <= '0;
      end else begin
         irq_req   <= enc_any;
         irq_level <= enc_any ? enc_idx : '0;
         lvl_pend  <= lvl_act;
      end
   end
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
   import irq_pkg::*;
#(
   parameter int N_EXT       = 2,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic [N_EXT-1:0] ext_irq,
   input logic [N_EXT-1:0] ext_s,
   input logic             irq_req,
   input lvl_t             irq_level,
   input lvl_vec_t         lvl_pend,
   input lvl_vec_t         lvl_en,
   input lvl_vec_t         isr_q
);
   lvl_vec_t isr_d;
   always_ff @(posedge clk) begin
      if (rst) isr_d <= '0;
      else     isr_d <= isr_q;
   end

   p_req_pending_r5: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> lvl_pend[irq_level]);

   p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
      !irq_req |-> irq_level == '0);

   p_pend_enabled_r6: assert property (@(posedge clk) disable iff (rst)
      (lvl_pend & ~$past(lvl_en)) == '0);

   p_ack_excluded_r9: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> !isr_d[irq_level]);

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         for (genvar i = 0; i < N_EXT; i++) begin : g_pin
            p_sync_rise_r8: assert property (@(posedge clk) disable iff (rst)
               $rose(ext_s[i]) |-> $past(ext_irq[i], 2));
            p_sync_fall_r8: assert property (@(posedge clk) disable iff (rst)
               $fell(ext_s[i]) |-> !$past(ext_irq[i], 2));
         end
      end
   endgenerate
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N_EXT(N_EXT), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst(rst), .ext_irq(ext_irq), .ext_s(ext_s),
   .irq_req(irq_req), .irq_level(irq_level), .lvl_pend(lvl_pend),
   .lvl_en(lvl_en), .isr_q(isr_q)
);

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] int_irq = '0;
   logic [1:0] ext_irq = '0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       ack_valid = 1'b0;
   logic [2:0] ack_level = '0;
   logic       irq_req;
   logic [2:0] irq_level;
   logic [7:0] lvl_pend;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   irq_level_ctrl dut (
      .clk(clk), .rst(rst), .int_irq(int_irq), .ext_irq(ext_irq),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .ack_valid(ack_valid), .ack_level(ack_level),
      .irq_req(irq_req), .irq_level(irq_level), .lvl_pend(lvl_pend)
   );

   // vector: {int_irq[5:0], exp_req, exp_level[2:0], exp_pend[7:0]}
   localparam logic [17:0] VEC [10] = '{
      {6'b000000, 1'b0, 3'd0, 8'h00},  // R5 idle
      {6'b000001, 1'b1, 3'd1, 8'h02},  // R3
      {6'b000011, 1'b1, 3'd3, 8'h0A},  // R5
      {6'b000110, 1'b1, 3'd3, 8'h08},  // R4 shared
      {6'b000100, 1'b1, 3'd3, 8'h08},  // R4 one left
      {6'b001101, 1'b1, 3'd7, 8'h8A},  // R5 top
      {6'b010000, 1'b1, 3'd0, 8'h01},  // R5 lowest
      {6'b100000, 1'b0, 3'd0, 8'h00},  // R7 disabled src
      {6'b110001, 1'b1, 3'd1, 8'h03},  // R7
      {6'b111111, 1'b1, 3'd7, 8'h8B}   // R5
   };

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
      @(negedge clk);
      cfg_addr = a;
      #1 chk(tag, {24'd0, cfg_rdata}, {24'd0, exp});
   endtask

   // drive at negedge, wait n edges, sample at the following negedge
   task automatic step(int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic out_chk(string tag, logic r, logic [2:0] l, logic [7:0] p);
      chk(tag, {23'd0, r, l, lvl_pend}, {23'd0, r, l, p} ^ {23'd0, r ^ irq_req, l ^ irq_level, 8'd0});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      @(negedge clk);
      chk("R1 req", {31'd0, irq_req}, 32'd0);
      chk("R1 level/pend", {21'd0, irq_level, lvl_pend}, 32'd0);
      rd_chk("R1 src0", 4'd0, 8'h00);
      rd_chk("R1 lvl_en", 4'd8, 8'h00);

      // R2 register map
      wr(4'd3, 8'hF9);
      rd_chk("R2 upper bits dropped", 4'd3, 8'h09);
      wr(4'd12, 8'hFF);
      rd_chk("R2 unused addr", 4'd12, 8'h00);
      rd_chk("R2 unused write no effect src", 4'd4, 8'h00);
      rd_chk("R2 unused write no effect en", 4'd8, 8'h00);

      wr(4'd0, 8'h09); wr(4'd1, 8'h0B); wr(4'd2, 8'h0B); wr(4'd3, 8'h0F);
      wr(4'd4, 8'h08); wr(4'd5, 8'h06); wr(4'd6, 8'h0C); wr(4'd7, 8'h0E);
      wr(4'd8, 8'hFF);
      rd_chk("R2 src7", 4'd7, 8'h0E);
      rd_chk("R2 lvl_en", 4'd8, 8'hFF);

      // table walk: R3 R4 R5 R7
      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         int_irq = VEC[v][17:12];
         step(1);
         chk($sformatf("R3/R4/R5/R7 vec%0d req", v), {31'd0, irq_req}, {31'd0, VEC[v][11]});
         chk($sformatf("R5 vec%0d level", v), {29'd0, irq_level}, {29'd0, VEC[v][10:8]});
         chk($sformatf("R4 vec%0d pend", v), {24'd0, lvl_pend}, {24'd0, VEC[v][7:0]});
      end

      // R6 level enable
      wr(4'd8, 8'h7F);
      int_irq = 6'b001001;
      step(1);
      chk("R6 lvl7 masked level", {29'd0, irq_level}, 32'd1);
      chk("R6 lvl7 masked pend", {24'd0, lvl_pend}, 32'h02);
      wr(4'd8, 8'h00);
      int_irq = 6'b111111;
      step(1);
      chk("R6 all disabled req", {31'd0, irq_req}, 32'd0);
      chk("R6 all disabled pend", {24'd0, lvl_pend}, 32'd0);
      wr(4'd8, 8'hFF);
      int_irq = '0;
      step(1);

      // R8 synchroniser latency
      @(negedge clk);
      ext_irq = 2'b01;
      step(2);
      chk("R8 not after two edges", {24'd0, lvl_pend}, 32'h00);
      step(1);
      chk("R8 ext0 after three edges pend", {24'd0, lvl_pend}, 32'h10);
      chk("R8 ext0 level", {29'd0, irq_level}, 32'd4);
      ext_irq = 2'b11;
      step(3);
      chk("R8 ext1 level", {29'd0, irq_level}, 32'd6);
      ext_irq = 2'b00;
      step(3);
      chk("R8 ext release", {31'd0, irq_req}, 32'd0);

      // R9 / R10 acknowledge
      int_irq = 6'b000011;
      step(1);
      chk("R9 before ack", {29'd0, irq_level}, 32'd3);
      ack_valid = 1'b1; ack_level = 3'd3;
      @(posedge clk); @(negedge clk);
      ack_valid = 1'b0;
      step(1);
      chk("R9 acked level skipped", {29'd0, irq_level}, 32'd1);
      chk("R10 pend kept after ack", {24'd0, lvl_pend}, 32'h0A);
      step(2);
      chk("R9 still skipped while high", {29'd0, irq_level}, 32'd1);
      int_irq = 6'b000001;
      step(1);
      chk("R9 level dropped", {24'd0, lvl_pend}, 32'h02);
      int_irq = 6'b000011;
      step(1);
      chk("R9 level eligible again", {29'd0, irq_level}, 32'd3);
      int_irq = 6'b000001;
      step(1);
      ack_valid = 1'b1; ack_level = 3'd1;
      @(posedge clk); @(negedge clk);
      ack_valid = 1'b0;
      step(1);
      chk("R9 only level acked req", {31'd0, irq_req}, 32'd0);
      chk("R10 only level acked pend", {24'd0, lvl_pend}, 32'h02);

      finish_run();
   end
endmodule